// File: doc/BRIEF.md
# Pipelined No-Turnaround Burst SRAM

This block is a synthesizable model of a synchronous static memory in which reads, writes and deselects all travel through one registered pipeline. Because of this, a read may follow a write, or a write a read, on adjacent clock edges with no idle cycle on the data bus. The memory holds 2^AW words. Each word is made of LANES byte lanes of LW bits, which is four 9-bit lanes (36 bits) by default. The shared bus is split into a data-in vector, a data-out vector and a drive-enable flag.

An access is loaded with a full address. A single load can be followed by advance beats that step a 2-bit burst counter through the two lowest address bits, in either linear or interleaved order. The read or write type chosen at load time holds for every beat of the burst. Read data appears one edge after the address edge. Write data and lane enables are taken one edge later than that, after the bus has been released. A read whose address matches the write still waiting for its data returns the merged new lanes.

Top module: `ntb_sram`

## Requirements
- R1: After reset, the pipeline is empty and `dq_oe` stays 0 until a read has completed.
- R2: An edge with `cke_n` = 1 is ignored. The pipeline, the burst counter, the loaded type and `dq_out` all hold.
- R3: An enabled edge with `adv_ld` = 0 and all three chip enables active (`cs_a_n` = 0, `cs_b` = 1, `cs_c_n` = 0) starts an access at `addr`. It is a write if `wr_n` = 0 and a read if `wr_n` = 1.
- R4: Read data for an address edge E is valid on `dq_out` after the next enabled edge. `dq_oe` is 1 only while `oe_n` is 0, and `oe_n` acts without a clock.
- R5: After a write address edge, `dq_oe` is 0 following the next enabled edge, whatever the value of `oe_n`. Write data is sampled on `dq_in` at the enabled edge after that one and is stored at the write address.
- R6: On a write, lane i (bits 9i+8 down to 9i) is updated only if `bw_n[i]` = 0 at the data edge. All other lanes keep their contents.
- R7: A load edge with any chip enable inactive is a deselect. If the previous access was a read, its data is still driven after the next edge, and `dq_oe` is 0 after the edge following that one.
- R8: An enabled edge with `adv_ld` = 1 advances the burst counter whatever the chip enables and `wr_n` are. While a burst is active, it issues the next beat. After a deselect, an advance issues nothing.
- R9: With `burst_ilv` = 0, beat k of a burst started at address A uses low bits (A[1:0]+k) mod 4. The upper bits stay the same, and the fifth beat wraps back to the start.
- R10: With `burst_ilv` = 1, beat k uses low bits A[1:0] XOR (k mod 4).
- R11: Every beat of a burst keeps the read or write type captured at load, even if `wr_n` changes during advances.
- R12: A read whose address equals the address of the write taking its data at that same edge returns the new data in the enabled lanes and the array contents in the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline (the array is not cleared) |
| cke_n | input | 1 | Clock enable, active low |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 = load a new address, 1 = advance the burst |
| wr_n | input | 1 | Access type at load: 0 = write, 1 = read |
| bw_n | input | LANES | Per-lane write enables, active low |
| burst_ilv | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Word address |
| dq_in | input | LANES*LW | Write data from the bus |
| dq_out | output | LANES*LW | Read data from the output register |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The assertions take for granted that `burst_ilv` does not change in the middle of a burst. They also assume `oe_n` changes only away from the sampling edge, since its effect is judged at the clock. The stimulus changes the mode only between bursts and drives every input at the falling edge. The one exception is a deliberate mid-cycle `oe_n` pulse, which the bench checks with an immediate comparison. Chip enables and `wr_n` are randomized during advance beats and stall cycles, so the checks show they have no effect there.

// File: rtl/ntb_sram_pkg.sv
package ntb_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // low address bits of a burst beat
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input logic       ilv);
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/ntb_sram_seq.sv
module ntb_sram_seq
    import ntb_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic          sel,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic          ilv,
    output op_e           acc_op,
    output logic [AW-1:0] acc_addr
);

    typedef struct packed {
        logic          act;
        logic          wr;
        logic [AW-1:0] base;
        logic [1:0]    cnt;
        op_e           op;
        logic [AW-1:0] a;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [1:0] cnt_inc;

    always_comb begin
        seq_d   = seq_q;
        cnt_inc = seq_q.cnt + 2'd1;
        if (step) begin
            if (load) begin
                if (sel) begin
                    seq_d.act  = 1'b1;
                    seq_d.wr   = !wr_n;
                    seq_d.base = addr;
                    seq_d.cnt  = 2'd0;
                    seq_d.op   = wr_n ? OP_READ : OP_WRITE;
                    seq_d.a    = addr;
                end else begin
                    seq_d.act = 1'b0;
                    seq_d.op  = OP_IDLE;
                end
            end else begin
                seq_d.cnt = cnt_inc;
                seq_d.a   = {seq_q.base[AW-1:2], beat_low(seq_q.base[1:0], cnt_inc, ilv)};
                if (!seq_q.act)
                    seq_d.op = OP_IDLE;
                else if (seq_q.wr)
                    seq_d.op = OP_WRITE;
                else
                    seq_d.op = OP_READ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seq_q <= '0;
        else
            seq_q <= seq_d;
    end

    assign acc_op   = seq_q.op;
    assign acc_addr = seq_q.a;

endmodule

// File: rtl/ntb_sram_mem.sv
module ntb_sram_mem #(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 9,
    localparam int DEPTH = 1 << AW,
    localparam int DW    = LANES * LW
) (
    input  logic             clk,
    input  logic             we,
    input  logic [LANES-1:0] lane_en,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LW-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[l])
                lane_mem[waddr] <= wdata[l*LW +: LW];
        end

        assign rdata[l*LW +: LW] = lane_mem[raddr];
    end

endmodule

// File: rtl/ntb_sram.sv
module ntb_sram
    import ntb_sram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 9,
    localparam int DW   = LANES * LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic             cs_a_n,
    input  logic             cs_b,
    input  logic             cs_c_n,
    input  logic             adv_ld,
    input  logic             wr_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             burst_ilv,
    input  logic             oe_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    dq_in,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe
);

    typedef struct packed {
        logic          wpend;
        logic [AW-1:0] waddr;
        logic          rvalid;
        logic [DW-1:0] dout;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic          sel;
    logic          step;
    op_e           s1_op;
    logic [AW-1:0] s1_addr;
    logic [DW-1:0] arr_rd;
    logic [DW-1:0] merged;
    logic          fwd_hit;

    assign sel  = !cs_a_n && cs_b && !cs_c_n;
    assign step = !cke_n;

    ntb_sram_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (!adv_ld),
        .sel      (sel),
        .wr_n     (wr_n),
        .addr     (addr),
        .ilv      (burst_ilv),
        .acc_op   (s1_op),
        .acc_addr (s1_addr)
    );

    ntb_sram_mem #(.AW(AW), .LANES(LANES), .LW(LW)) u_mem (
        .clk     (clk),
        .we      (step && pipe_q.wpend),
        .lane_en (~bw_n),
        .waddr   (pipe_q.waddr),
        .wdata   (dq_in),
        .raddr   (s1_addr),
        .rdata   (arr_rd)
    );

    assign fwd_hit = pipe_q.wpend && (pipe_q.waddr == s1_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign merged[l*LW +: LW] = (fwd_hit && !bw_n[l]) ? dq_in[l*LW +: LW]
                                                           : arr_rd[l*LW +: LW];
    end

    always_comb begin
        pipe_d = pipe_q;
        if (step) begin
            pipe_d.wpend  = (s1_op == OP_WRITE);
            pipe_d.waddr  = s1_addr;
            pipe_d.rvalid = (s1_op == OP_READ);
            if (s1_op == OP_READ)
                pipe_d.dout = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pipe_q <= '0;
        else
            pipe_q <= pipe_d;
    end

    assign dq_out = pipe_q.dout;
    assign dq_oe  = pipe_q.rvalid && !oe_n;

endmodule

// File: rtl/ntb_sram_chk.sv
module ntb_sram_chk
    import ntb_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cke_n,
    input logic          adv_ld,
    input logic          wr_n,
    input logic          sel,
    input logic          oe_n,
    input logic          burst_ilv,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] dq_out,
    input logic          dq_oe,
    input op_e           s1_op,
    input logic [AW-1:0] s1_addr
);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(dq_out) && $stable(s1_addr) && s1_op == $past(s1_op)));

    // R3
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && sel) |=>
            (s1_addr == $past(addr) && s1_op == ($past(wr_n) ? OP_READ : OP_WRITE)));

    // R4
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s1_op == OP_READ) |=> (dq_oe == !oe_n));

    // R5
    write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s1_op == OP_WRITE) |=> !dq_oe);

    // R7
    deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s1_op == OP_IDLE) |=> !dq_oe);

    // R11
    burst_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && s1_op != OP_IDLE) |=>
            (s1_op == $past(s1_op) && s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));

    // R9
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && s1_op != OP_IDLE && !burst_ilv) |=>
            (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1));

endmodule

bind ntb_sram ntb_sram_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_n     (cke_n),
    .adv_ld    (adv_ld),
    .wr_n      (wr_n),
    .sel       (sel),
    .oe_n      (oe_n),
    .burst_ilv (burst_ilv),
    .addr      (addr),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .s1_op     (s1_op),
    .s1_addr   (s1_addr)
);

// File: tb/test_ntb_sram.sv
module test_ntb_sram;

    localparam int AW    = 6;
    localparam int LANES = 4;
    localparam int LW    = 9;
    localparam int DW    = LANES * LW;
    localparam int DEPTH = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cke_n = 1'b0;
    logic             cs_a_n = 1'b1;
    logic             cs_b = 1'b0;
    logic             cs_c_n = 1'b1;
    logic             adv_ld = 1'b0;
    logic             wr_n = 1'b1;
    logic [LANES-1:0] bw_n = '1;
    logic             burst_ilv = 1'b0;
    logic             oe_n = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [DW-1:0]    dq_in = '0;
    logic [DW-1:0]    dq_out;
    logic             dq_oe;

    int errors = 0;
    int checks = 0;

    // reference state
    logic [DW-1:0] ref_mem [DEPTH];
    bit            m_act, m_wr;
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    bit            m_p1v, m_p1w;
    logic [AW-1:0] m_p1a;
    bit            m_p2v;
    logic [AW-1:0] m_p2a;
    bit            m_ov;
    logic [DW-1:0] m_od;
    bit            full_bw = 1'b1;

    always #5 clk = ~clk;

    ntb_sram #(.AW(AW), .LANES(LANES), .LW(LW)) i_ntb_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
        .cs_c_n(cs_c_n), .adv_ld(adv_ld), .wr_n(wr_n), .bw_n(bw_n),
        .burst_ilv(burst_ilv), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check_out(input string tag);
        bit exp_drv;
        exp_drv = m_ov && !oe_n;
        checks++;
        if (dq_oe !== exp_drv || (exp_drv && dq_out !== m_od)) begin
            errors++;
            $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                     tag, dq_oe, dq_out, exp_drv, m_od);
        end
    endtask

    // one clock: drive at falling edge, update model at rising edge, check after it
    task automatic cyc(input bit ck_n, input bit adv, input bit on, input bit wn,
                       input int a, input bit oe, input string tag);
        int off;
        @(negedge clk);
        cke_n  = ck_n;
        adv_ld = adv;
        off    = on ? 3 : int'($urandom % 3);
        cs_a_n = (off == 0);
        cs_b   = (off != 1);
        cs_c_n = (off == 2);
        wr_n   = wn;
        addr   = AW'(a);
        oe_n   = oe;
        bw_n   = (m_p2v && full_bw) ? '0 : LANES'($urandom);
        dq_in  = {4'($urandom), $urandom};
        @(posedge clk);
        if (!ck_n) begin
            if (m_p2v)
                for (int l = 0; l < LANES; l++)
                    if (!bw_n[l]) ref_mem[m_p2a][l*LW +: LW] = dq_in[l*LW +: LW];
            m_ov = m_p1v && !m_p1w;
            if (m_ov) m_od = ref_mem[m_p1a];
            m_p2v = m_p1v && m_p1w;
            m_p2a = m_p1a;
            if (!adv) begin
                if (on) begin
                    m_act = 1; m_wr = !wn; m_base = AW'(a); m_cnt = 0;
                    m_p1v = 1; m_p1w = !wn; m_p1a = AW'(a);
                end else begin
                    m_act = 0; m_p1v = 0;
                end
            end else begin
                m_cnt = m_cnt + 2'd1;
                m_p1v = m_act;
                m_p1w = m_wr;
                m_p1a = {m_base[AW-1:2],
                         burst_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
            end
        end
        #2;
        check_out(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int a;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (dq_oe !== 1'b0) begin
            errors++;
            $display("FAIL R1: drive=%0b expected drive=0", dq_oe);
        end
        cyc(0, 1, 1, 1, 0, 0, "R1");   // advance with no burst: nothing issued (R8)
        cyc(0, 1, 1, 0, 0, 0, "R8");

        // fill: linear write bursts of full words (R5, R11)
        full_bw = 1;
        burst_ilv = 0;
        for (int b = 0; b < DEPTH / 4; b++) begin
            cyc(0, 0, 1, 0, 4 * b, 0, "R5");
            for (int k = 1; k < 4; k++)
                cyc(0, 1, $urandom % 2, $urandom % 2, $urandom, 0, "R11");
        end
        cyc(0, 0, 0, 1, 0, 0, "R7");
        cyc(0, 0, 0, 1, 0, 0, "R7");

        // read back with linear bursts (R4, R9)
        for (int b = 0; b < DEPTH / 4; b++) begin
            cyc(0, 0, 1, 1, 4 * b, 0, "R4");
            for (int k = 1; k < 4; k++)
                cyc(0, 1, $urandom % 2, $urandom % 2, $urandom, 0, "R9");
        end

        // alternating writes with lane enables and immediate reads (R6, R12, R3)
        full_bw = 0;
        for (int i = 0; i < DEPTH; i++) begin
            cyc(0, 0, 1, 0, i, 0, "R6");
            cyc(0, 0, 1, 1, i, 0, "R12");
            cyc(0, 0, 1, 1, (i * 7 + 3) % DEPTH, 0, "R3");
        end

        // bursts in both orders from every start, with stalls and wrap (R2, R9, R10, R11)
        for (int m = 0; m < 2; m++) begin
            cyc(0, 0, 0, 1, 0, 0, "R7");
            burst_ilv = m[0];
            for (int s = 0; s < 4; s++) begin
                a = int'(($urandom % (DEPTH / 4)) * 4) + s;
                cyc(0, 0, 1, 0, a, 0, "R11");
                for (int k = 1; k < 5; k++) begin
                    cyc(0, 1, $urandom % 2, $urandom % 2, $urandom, 0, "R11");
                    if (k == 2) cyc(1, $urandom % 2, $urandom % 2, $urandom % 2, $urandom, 0, "R2");
                end
                cyc(0, 0, 1, 1, a, 0, m ? "R10" : "R9");
                for (int k = 1; k < 5; k++) begin
                    cyc(0, 1, $urandom % 2, $urandom % 2, $urandom, 0, m ? "R10" : "R9");
                    if (k == 1) begin
                        cyc(1, $urandom % 2, $urandom % 2, $urandom % 2, $urandom, 0, "R2");
                        cyc(1, $urandom % 2, $urandom % 2, $urandom % 2, $urandom, 0, "R2");
                    end
                end
            end
        end
        burst_ilv = 0;

        // pipelined deselect and asynchronous output enable (R7, R4)
        cyc(0, 0, 1, 1, 5, 0, "R7");
        cyc(0, 0, 0, 1, 6, 0, "R7");
        cyc(0, 0, 0, 1, 7, 0, "R7");
        cyc(0, 1, 1, 1, 7, 0, "R8");
        cyc(0, 0, 1, 1, 9, 1, "R4");
        cyc(0, 0, 1, 1, 10, 1, "R4");
        cyc(0, 0, 1, 1, 11, 0, "R4");
        #1 oe_n = 1'b1;
        #1;
        checks++;
        if (dq_oe !== 1'b0) begin
            errors++;
            $display("FAIL R4: drive=%0b expected drive=0 with oe_n high", dq_oe);
        end
        oe_n = 1'b0;
        #1;
        check_out("R4");
        cyc(0, 0, 1, 0, 12, 1, "R5");
        cyc(0, 0, 1, 1, 12, 1, "R5");
        cyc(0, 0, 0, 1, 0, 0, "R12");
        cyc(0, 0, 0, 1, 0, 0, "R7");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule